// File: doc/BRIEF.md
# NTSC Composite Sync Generator

This block produces the full timing of a monochrome interlaced NTSC composite signal from one reference clock. On every clock it emits a 2-bit level code. An external resistor ladder turns that code into the sync, blank, black and white voltages. The durations of the line, the porches, the horizontal sync, the equalising pulses and the serrations are all computed in clock cycles from the clock frequency parameter and a set of nanosecond parameters.

Alongside the level code the block emits three more signals, so that a pixel source can supply on/off picture data through the `pix_on` input:
- an active-video flag;
- the current line number within the field;
- the current field.

A frame is two fields. The even field has 262 lines and starts its vertical pattern at the start of a line. The odd field has 263 lines and starts its vertical pattern at the midpoint of its first line, which gives the half-line interlace offset.

The sequencing is held by a segment state machine. Its states are:
- `S_HSYNC`: horizontal sync.
- `S_BACK`: back porch.
- `S_ACTIVE`: picture.
- `S_FRONT`: front porch.
- `S_BLANK`: blanked remainder of a line or half-line.
- `S_EQ_SYNC`: narrow equalising pulse.
- `S_EQ_GAP`: blank after the equalising pulse.
- `S_BROAD`: wide inverted pulse.
- `S_SERR`: serration after the wide pulse.

Its transitions are:
- HSYNC→BACK on an active line, or HSYNC→BLANK on a blanking line, after the sync width.
- BACK→ACTIVE after the back porch.
- ACTIVE→FRONT at the start of the front porch.
- EQ_SYNC→EQ_GAP after the equalising width.
- BROAD→SERR at the serration point.
- From FRONT, BLANK, EQ_GAP or SERR at a half-line or line boundary to the first segment of the next half-line or line: EQ_SYNC, BROAD, BLANK or HSYNC.

Reset enters EQ_SYNC.

Top module: `ntsc_sync_gen`

## Requirements
- R1: During and right after reset the block is at the first cycle of field 0, line 0: `level` = 00 (sync), `active` = 0, `line_no` = 0, `field_odd` = 0.
- R2: Each line lasts LINE cycles and starts with horizontal sync. On lines 12 and above, the line is HS cycles of code 00, then BP cycles of code 01, then the picture, then FP cycles of code 01 at the end of the line. With the bench clock of 2 MHz these are LINE=127, HS=9, BP=9 and FP=3.
- R3: During the picture the code is 11 (white) when `pix_on` is 1 and 10 (black) when it is 0, in the same cycle as `pix_on`.
- R4: Lines 0 to 11 of each field carry no picture. Outside the vertical pattern they show only code 00 for HS cycles at the line start, and 01 for the rest.
- R5: The vertical pattern is 18 half-lines. Half-lines 0–5 and 12–17 are equalising half-lines: EQ cycles of 00 (EQ=4 at 2 MHz), then 01 to the end of the half-line. The first half of a line is LINE/2 cycles, rounded down, and the second half takes the rest.
- R6: Half-lines 6–11 of the vertical pattern are broad half-lines: 00 for the half-line length minus SERR cycles (SERR=9 at 2 MHz), then SERR cycles of 01.
- R7: Field 0 has 262 lines and its pattern starts at line 0, cycle 0. Field 1 has 263 lines and its pattern starts at the midpoint of line 0. The first half of that line 0 is an ordinary blanking half with horizontal sync.
- R8: `field_odd` toggles at the first cycle of each field. At that cycle `line_no` restarts at 0, and otherwise it only steps up by one at line starts.
- R9: `active` is 1 exactly in the picture cycles of lines 12 and above, and never while the code is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, CLK_HZ |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_on | input | 1 | Pixel data for the current cycle: 1 = white |
| level | output | 2 | Level code: 00 sync, 01 blank, 10 black, 11 white |
| active | output | 1 | High during picture cycles |
| line_no | output | 9 | Line number within the current field |
| field_odd | output | 1 | 0 for the 262-line field, 1 for the 263-line field |

## Verification
`level` follows `pix_on` combinationally, so a pixel value driven in a cycle must appear in that same cycle. The bench therefore drives `pix_on` shortly after each rising edge and samples a few nanoseconds later, before the falling edge.

The segment state, `active`, `line_no` and `field_odd` are all registers updated on the same edge. After that edge they describe cycle t, where t counts rising edges since reset was released. The reference model works out the expected segment for cycle t directly from t modulo the frame length, with no delay term. It compares every output once per cycle over two whole frames.

The field-length check is made at the cycle where `field_odd` changes. It compares against the last `line_no` seen in the field just ended.

// File: rtl/ntsc_sync_pkg.sv
package ntsc_sync_pkg;

    typedef enum logic [3:0] {
        S_HSYNC,
        S_BACK,
        S_ACTIVE,
        S_FRONT,
        S_BLANK,
        S_EQ_SYNC,
        S_EQ_GAP,
        S_BROAD,
        S_SERR
    } seg_e;

    localparam logic [1:0] LVL_SYNC  = 2'b00;
    localparam logic [1:0] LVL_BLANK = 2'b01;
    localparam logic [1:0] LVL_BLACK = 2'b10;
    localparam logic [1:0] LVL_WHITE = 2'b11;

    // Rounded conversion of a nanosecond duration into clock cycles.
    function automatic int ns_to_cyc(input longint hz, input longint ns);
        return int'((ns * hz + 64'd500000000) / 64'd1000000000);
    endfunction

endpackage

// File: rtl/ntsc_raster_counter.sv
module ntsc_raster_counter #(
    parameter int LINE_CYC = 762,
    parameter int F0_LINES = 262,
    parameter int HW       = 10,
    parameter int LW       = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [HW-1:0] hcnt,
    output logic [LW-1:0] line,
    output logic          field,
    output logic [LW-1:0] line_nxt,
    output logic          field_nxt,
    output logic          line_end
);

    localparam logic [HW-1:0] H_LAST  = HW'(LINE_CYC - 1);
    localparam logic [LW-1:0] L_LAST0 = LW'(F0_LINES - 1);
    localparam logic [LW-1:0] L_LAST1 = LW'(F0_LINES);

    logic [LW-1:0] last_line;

    always_comb begin
        line_end  = (hcnt == H_LAST);
        last_line = field ? L_LAST1 : L_LAST0;
        if (line == last_line) begin
            line_nxt  = '0;
            field_nxt = ~field;
        end else begin
            line_nxt  = line + 1'b1;
            field_nxt = field;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hcnt  <= '0;
            line  <= '0;
            field <= 1'b0;
        end else if (line_end) begin
            hcnt  <= '0;
            line  <= line_nxt;
            field <= field_nxt;
        end else begin
            hcnt  <= hcnt + 1'b1;
        end
    end

endmodule

// File: rtl/ntsc_seg_fsm.sv
module ntsc_seg_fsm
    import ntsc_sync_pkg::*;
#(
    parameter int LINE_CYC  = 762,
    parameter int HALF_A    = 381,
    parameter int FP_CYC    = 17,
    parameter int HS_CYC    = 53,
    parameter int BP_CYC    = 53,
    parameter int EQ_CYC    = 26,
    parameter int SERR_CYC  = 53,
    parameter int VB_LINES  = 12,
    parameter int EQ_HALVES = 6,
    parameter int HW        = 10,
    parameter int LW        = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [HW-1:0] hcnt,
    input  logic [LW-1:0] line,
    input  logic          field,
    input  logic [LW-1:0] line_nxt,
    input  logic          field_nxt,
    input  logic          line_end,
    output seg_e          state
);

    localparam logic [HW-1:0] H_HS_END   = HW'(HS_CYC - 1);
    localparam logic [HW-1:0] H_BP_END   = HW'(HS_CYC + BP_CYC - 1);
    localparam logic [HW-1:0] H_ACT_END  = HW'(LINE_CYC - FP_CYC - 1);
    localparam logic [HW-1:0] H_HALF     = HW'(HALF_A);
    localparam logic [HW-1:0] H_HALF_END = HW'(HALF_A - 1);
    localparam logic [HW-1:0] P_EQ_END   = HW'(EQ_CYC - 1);
    localparam logic [HW-1:0] P_BRA_END  = HW'(HALF_A - SERR_CYC - 1);
    localparam logic [HW-1:0] P_BRB_END  = HW'(LINE_CYC - HALF_A - SERR_CYC - 1);
    localparam logic [LW-1:0] L_VB       = LW'(VB_LINES);
    localparam int            PAT_HALVES = 3 * EQ_HALVES;

    seg_e          state_q, state_d;
    logic          half;
    logic [HW-1:0] pos;

    // First segment of a half-line (hf=1) or line (hf=0).
    function automatic seg_e first_seg(input int ln, input int fld, input int hf);
        int hl;
        int rel;
        hl  = 2 * ln + hf;
        rel = hl - fld;
        if (hl >= fld && rel < PAT_HALVES) begin
            if (rel < EQ_HALVES || rel >= 2 * EQ_HALVES)
                return S_EQ_SYNC;
            else
                return S_BROAD;
        end else if (hf != 0) begin
            return S_BLANK;
        end else begin
            return S_HSYNC;
        end
    endfunction

    always_comb begin
        half    = (hcnt >= H_HALF);
        pos     = half ? (hcnt - H_HALF) : hcnt;
        state_d = state_q;
        unique case (state_q)
            S_HSYNC: begin
                if (hcnt == H_HS_END)
                    state_d = (line < L_VB) ? S_BLANK : S_BACK;
            end
            S_BACK: begin
                if (hcnt == H_BP_END)
                    state_d = S_ACTIVE;
            end
            S_ACTIVE: begin
                if (hcnt == H_ACT_END)
                    state_d = S_FRONT;
            end
            S_FRONT: begin
                if (line_end)
                    state_d = first_seg(int'(line_nxt), int'(field_nxt), 0);
            end
            S_EQ_SYNC: begin
                if (pos == P_EQ_END)
                    state_d = S_EQ_GAP;
            end
            S_BROAD: begin
                if (pos == (half ? P_BRB_END : P_BRA_END))
                    state_d = S_SERR;
            end
            S_BLANK, S_EQ_GAP, S_SERR: begin
                if (hcnt == H_HALF_END)
                    state_d = first_seg(int'(line), int'(field), 1);
                else if (line_end)
                    state_d = first_seg(int'(line_nxt), int'(field_nxt), 0);
            end
            default: state_d = S_BLANK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= S_EQ_SYNC;
        else
            state_q <= state_d;
    end

    assign state = state_q;

endmodule

// File: rtl/ntsc_level_enc.sv
module ntsc_level_enc
    import ntsc_sync_pkg::*;
(
    input  seg_e       state,
    input  logic       pix_on,
    output logic [1:0] level,
    output logic       active
);

    always_comb begin
        active = 1'b0;
        level  = LVL_BLANK;
        unique case (state)
            S_HSYNC, S_EQ_SYNC, S_BROAD: level = LVL_SYNC;
            S_BACK, S_FRONT, S_BLANK,
            S_EQ_GAP, S_SERR:            level = LVL_BLANK;
            S_ACTIVE: begin
                active = 1'b1;
                level  = pix_on ? LVL_WHITE : LVL_BLACK;
            end
            default:                     level = LVL_BLANK;
        endcase
    end

endmodule

// File: rtl/ntsc_sync_gen.sv
module ntsc_sync_gen
    import ntsc_sync_pkg::*;
#(
    parameter int CLK_HZ    = 12_000_000,
    parameter int LINE_NS   = 63_500,
    parameter int FP_NS     = 1_400,
    parameter int HS_NS     = 4_400,
    parameter int BP_NS     = 4_400,
    parameter int EQ_NS     = 2_200,
    parameter int SERR_NS   = 4_400,
    parameter int F0_LINES  = 262,
    parameter int VB_LINES  = 12,
    parameter int EQ_HALVES = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pix_on,
    output logic [1:0] level,
    output logic       active,
    output logic [8:0] line_no,
    output logic       field_odd
);

    localparam int LINE_CYC = ns_to_cyc(CLK_HZ, LINE_NS);
    localparam int FP_CYC   = ns_to_cyc(CLK_HZ, FP_NS);
    localparam int HS_CYC   = ns_to_cyc(CLK_HZ, HS_NS);
    localparam int BP_CYC   = ns_to_cyc(CLK_HZ, BP_NS);
    localparam int EQ_CYC   = ns_to_cyc(CLK_HZ, EQ_NS);
    localparam int SERR_CYC = ns_to_cyc(CLK_HZ, SERR_NS);
    localparam int HALF_A   = LINE_CYC / 2;
    localparam int HW       = $clog2(LINE_CYC);
    localparam int LW       = 9;

    logic [HW-1:0] hcnt;
    logic [LW-1:0] line, line_nxt;
    logic          field, field_nxt, line_end;
    seg_e          state;

    ntsc_raster_counter #(
        .LINE_CYC (LINE_CYC),
        .F0_LINES (F0_LINES),
        .HW       (HW),
        .LW       (LW)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .hcnt      (hcnt),
        .line      (line),
        .field     (field),
        .line_nxt  (line_nxt),
        .field_nxt (field_nxt),
        .line_end  (line_end)
    );

    ntsc_seg_fsm #(
        .LINE_CYC  (LINE_CYC),
        .HALF_A    (HALF_A),
        .FP_CYC    (FP_CYC),
        .HS_CYC    (HS_CYC),
        .BP_CYC    (BP_CYC),
        .EQ_CYC    (EQ_CYC),
        .SERR_CYC  (SERR_CYC),
        .VB_LINES  (VB_LINES),
        .EQ_HALVES (EQ_HALVES),
        .HW        (HW),
        .LW        (LW)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .hcnt      (hcnt),
        .line      (line),
        .field     (field),
        .line_nxt  (line_nxt),
        .field_nxt (field_nxt),
        .line_end  (line_end),
        .state     (state)
    );

    ntsc_level_enc u_enc (
        .state  (state),
        .pix_on (pix_on),
        .level  (level),
        .active (active)
    );

    assign line_no   = line;
    assign field_odd = field;

endmodule

// File: rtl/ntsc_sync_checker.sv
module ntsc_sync_checker #(
    parameter int F0_LINES = 262,
    parameter int VB_LINES = 12
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] level,
    input logic       active,
    input logic [8:0] line_no,
    input logic       field_odd
);

    localparam logic [8:0] L_VB    = 9'(VB_LINES);
    localparam logic [8:0] L_LAST0 = 9'(F0_LINES - 1);
    localparam logic [8:0] L_LAST1 = 9'(F0_LINES);

    // R3: picture cycles use only the black or white codes
    p_active_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> level[1]);

    // R4: no picture on vertical blanking lines
    p_no_pic_vblank_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (line_no < L_VB) |-> !active);

    // R9: sync level never coincides with the active flag
    p_sync_not_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (level == 2'b00) |-> !active);

    // R7: line number stays inside the field length
    p_line_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        line_no <= (field_odd ? L_LAST1 : L_LAST0));

    // R8: field flag changes only where the line number restarts
    p_field_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (field_odd != $past(field_odd)) |-> (line_no == 9'd0));

    // R8: line number moves only by one step or back to zero
    p_line_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (line_no != $past(line_no)) |->
            (line_no == 9'($past(line_no) + 9'd1) || line_no == 9'd0));

endmodule

bind ntsc_sync_gen ntsc_sync_checker #(
    .F0_LINES (F0_LINES),
    .VB_LINES (VB_LINES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .level     (level),
    .active    (active),
    .line_no   (line_no),
    .field_odd (field_odd)
);

// File: tb/test_ntsc_sync_gen.sv
`timescale 1ns/1ps
module test_ntsc_sync_gen;

    // Expected cycle counts at a 2 MHz reference (rounded from the ns figures)
    localparam int LINE  = 127;
    localparam int HS    = 9;
    localparam int BP    = 9;
    localparam int FP    = 3;
    localparam int EQ    = 4;
    localparam int SERR  = 9;
    localparam int HA    = LINE / 2;
    localparam int FRAME = 525 * LINE;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pix_on = 1'b0;
    logic [1:0] level;
    logic       active;
    logic [8:0] line_no;
    logic       field_odd;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    ntsc_sync_gen #(.CLK_HZ(2_000_000)) i_ntsc_sync_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_on    (pix_on),
        .level     (level),
        .active    (active),
        .line_no   (line_no),
        .field_odd (field_odd)
    );

    task automatic chk(input string req, input int act, input int exp, input string what);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Behavioural reference: position in the frame from the cycle index
    task automatic model(input int t, input bit px, output int lv, output int act,
                         output int ln, output int fd, output string tag);
        int f, h, hf, pos, hlen, hl, rel;
        f = t % FRAME;
        if (f < 262 * LINE) begin fd = 0; ln = f / LINE; end
        else                begin fd = 1; ln = (f - 262 * LINE) / LINE; end
        h    = f % LINE;
        hf   = (h >= HA) ? 1 : 0;
        pos  = hf ? h - HA : h;
        hlen = hf ? LINE - HA : HA;
        hl   = 2 * ln + hf;
        rel  = hl - fd;
        act  = 0;
        if (hl >= fd && rel < 18) begin
            if (rel < 6 || rel >= 12) begin
                tag = "R5"; lv = (pos < EQ) ? 0 : 1;
            end else begin
                tag = "R6"; lv = (pos < hlen - SERR) ? 0 : 1;
            end
        end else if (ln < 12) begin
            tag = (fd == 1 && ln == 0) ? "R7" : "R4";
            lv  = (hf == 0 && h < HS) ? 0 : 1;
        end else if (h < HS) begin
            tag = "R2"; lv = 0;
        end else if (h < HS + BP) begin
            tag = "R2"; lv = 1;
        end else if (h < LINE - FP) begin
            tag = "R3"; lv = px ? 3 : 2; act = 1;
        end else begin
            tag = "R2"; lv = 1;
        end
    endtask

    task automatic compare(input int t);
        int lv, act, ln, fd;
        string tag;
        model(t, pix_on, lv, act, ln, fd, tag);
        chk(tag,  int'(level),     lv,  "level");
        chk("R9", int'(active),    act, "active");
        chk("R8", int'(line_no),   ln,  "line_no");
        chk("R8", int'(field_odd), fd,  "field_odd");
    endtask

    initial begin : main
        int t;
        int last_line;
        bit prev_field;
        repeat (3) @(posedge clk);
        #2;
        // R1: state while reset is held
        chk("R1", int'(level), 0, "level in reset");
        chk("R1", int'(active), 0, "active in reset");
        chk("R1", int'(line_no), 0, "line_no in reset");
        chk("R1", int'(field_odd), 0, "field_odd in reset");
        @(negedge clk);
        rst_n = 1'b1;
        t = 0;
        #1 pix_on = 1'(($urandom() >> 4) & 1);
        #2 compare(t);
        last_line  = 0;
        prev_field = 1'b0;
        while (t < 2 * FRAME + 400) begin
            @(posedge clk);
            t++;
            #1 pix_on = 1'(($urandom() >> 4) & 1);
            #2 compare(t);
            // R7: field length seen at each field change
            if (field_odd != prev_field) begin
                chk("R7", last_line, prev_field ? 262 : 261, "last line of field");
                prev_field = field_odd;
            end
            last_line = int'(line_no);
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : watchdog
        repeat (190_000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule